// File: doc/BRIEF.md
# Non-secure interrupt access permission gate

This block holds a two-bit access level for every interrupt in the extended shared range of an interrupt distributor. It also decides, within the same cycle, whether a non-secure agent may touch that interrupt's state. The levels live in 32-bit permission words. Only the secure side can write them, over a simple request/write-enable register port. Each word packs sixteen levels. The field at bits [2x+1:2x] of word n belongs to interrupt 16n+x.

Surrounding distributor logic presents every access it is about to perform on the check port, and uses the single allow bit to pass or block it. The access is described by an interrupt index, an access class, a read/write flag and a non-secure flag. The secure/non-secure group of each interrupt and a per-interrupt "access is configurable" flag come in as vectors. A presence input says whether the extended range exists at all. The block holds no pending, active or routing state of its own.

Top module: `nsg_gate`

## Requirements
- R1: After reset every level is 0b00: each permission word reads zero, and non-secure requests for secure-group interrupts are denied in every class.
- R2: Word n (n < (RANGE+1)*2) answers at byte offset 0x3600 + 4n, and its bits [2x+1:2x] are the level of interrupt 16n+x. A misaligned offset or one past the last word reads zero and writes nothing.
- R3: Only secure register writes update a word. A non-secure read returns zero, and a non-secure write changes no stored level.
- R4: When cfg_ok_i of an interrupt is 0, its field reads zero, acts as level 0b00, and discards written data, so it still reads zero once cfg_ok_i is raised.
- R5: While ext_en_i is 0, every word reads zero, writes are discarded and all levels act as 0b00.
- R6: A secure request (chk_ns_i=0) is always allowed. A non-secure request for a non-secure-group interrupt (irq_ns_i bit 1) is allowed for classes 0 to 5 whatever its level.
- R7: For a secure-group interrupt at level 0b00, every non-secure request is denied.
- R8: Level 0b01 allows non-secure reads and writes of class 0 (set-pending) and class 4 (message set). It denies classes 1, 2, 3 and 5.
- R9: Level 0b10 also allows class 1 (clear-pending), class 5 (message clear) and reads of class 2 (active state). Class 3 (routing) stays denied.
- R10: A non-secure write of class 2 (active state) to a secure-group interrupt is denied at every level.
- R11: Level 0b11 allows everything 0b10 allows, plus reads and writes of class 3 (routing).
- R12: Class codes 6 and 7 are reserved and are denied for every non-secure request.
- R13: A secure write to a word takes effect at the clock edge, and the check in the next cycle already uses the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_en_i | input | 1 | Extended interrupt range present |
| irq_ns_i | input | NUM_IRQ | Group per interrupt, 1 = non-secure |
| cfg_ok_i | input | NUM_IRQ | Per interrupt, 1 = non-secure access level is configurable |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_ns_i | input | 1 | Register access comes from the non-secure side |
| reg_addr_i | input | 16 | Byte offset in the distributor frame |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid while a read is presented |
| chk_irq_i | input | IRQ_W | Interrupt index to check |
| chk_cls_i | input | 3 | Access class: 0 set-pend, 1 clr-pend, 2 active, 3 route, 4 msg-set, 5 msg-clr |
| chk_wr_i | input | 1 | Checked access is a write |
| chk_ns_i | input | 1 | Checked access is non-secure |
| chk_allow_o | output | 1 | Access permitted |

## Verification
The stored levels are the only state, and they reach the ports in two ways. A secure readback of the word shows them in the same cycle. The allow bit shows them for any interrupt on the very next check. A level that is corrupted, lost, or written through a forbidden path therefore turns into a wrong allow bit for some class, or a wrong read word, one cycle after the offending write. The bench loads known levels, walks each class against every level boundary, and then reads the words back after each denied write path.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
  localparam int unsigned FLD_PER_REG = 16;
  localparam int unsigned ADDR_W      = 16;
  localparam logic [15:0] BASE_OFF    = 16'h3600;

  typedef enum logic [2:0] {
    CLS_SET_PEND = 3'd0,
    CLS_CLR_PEND = 3'd1,
    CLS_ACTIVE   = 3'd2,
    CLS_ROUTE    = 3'd3,
    CLS_MSG_SET  = 3'd4,
    CLS_MSG_CLR  = 3'd5
  } acc_cls_e;

  typedef enum logic [1:0] {
    LVL_NONE  = 2'b00,
    LVL_SET   = 2'b01,
    LVL_CLEAR = 2'b10,
    LVL_ROUTE = 2'b11
  } acc_lvl_e;
endpackage

// File: rtl/nsg_addr_dec.sv
module nsg_addr_dec #(
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [15:0]      addr_i,
  output logic             hit_o,
  output logic [REG_W-1:0] idx_o
);
  import nsg_pkg::*;

  logic [15:0] off;

  always_comb begin
    off   = addr_i - BASE_OFF;
    hit_o = (addr_i >= BASE_OFF) && (off[1:0] == 2'b00) &&
            ({2'b00, off[15:2]} < 16'(NUM_REGS));
    idx_o = off[REG_W+1:2];
  end
endmodule

// File: rtl/nsg_regbank.sv
module nsg_regbank #(
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned NUM_IRQ = NUM_REGS * 16,
  localparam int unsigned REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_W-1:0]     idx_i,
  input  logic [31:0]          wdata_i,
  input  logic [NUM_IRQ-1:0]   cfg_ok_i,
  output logic [2*NUM_IRQ-1:0] lvl_q_o,
  output logic [31:0]          rd_word_o
);
  import nsg_pkg::*;

  logic [2*NUM_IRQ-1:0] lvl_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar f = 0; f < FLD_PER_REG; f++) begin : g_fld
      localparam int unsigned IRQ = r * FLD_PER_REG + f;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lvl_q[2*IRQ +: 2] <= LVL_NONE;
        end else if (wr_en_i && (idx_i == REG_W'(r))) begin
          // non-configurable fields drop the write
          lvl_q[2*IRQ +: 2] <= cfg_ok_i[IRQ] ? wdata_i[2*f +: 2] : LVL_NONE;
        end
      end
    end
  end

  always_comb begin
    rd_word_o = '0;
    for (int f = 0; f < FLD_PER_REG; f++) begin
      rd_word_o[2*f +: 2] = lvl_q[2*(int'(idx_i)*FLD_PER_REG + f) +: 2] &
                            {2{cfg_ok_i[int'(idx_i)*FLD_PER_REG + f]}};
    end
  end

  assign lvl_q_o = lvl_q;
endmodule

// File: rtl/nsg_check.sv
module nsg_check #(
  parameter int unsigned NUM_IRQ  = 64,
  localparam int unsigned IRQ_W   = $clog2(NUM_IRQ)
) (
  input  logic [2*NUM_IRQ-1:0] eff_lvl_i,
  input  logic [NUM_IRQ-1:0]   irq_ns_i,
  input  logic [IRQ_W-1:0]     irq_i,
  input  logic [2:0]           cls_i,
  input  logic                 wr_i,
  input  logic                 ns_i,
  output logic                 allow_o
);
  import nsg_pkg::*;

  logic [1:0] lvl;
  logic       known_cls;
  logic       perm;

  always_comb begin
    lvl       = eff_lvl_i[2*int'(irq_i) +: 2];
    known_cls = 1'b1;
    perm      = 1'b0;
    case (cls_i)
      CLS_SET_PEND, CLS_MSG_SET: perm = (lvl != LVL_NONE);
      CLS_CLR_PEND, CLS_MSG_CLR: perm = lvl[1];
      CLS_ACTIVE:                perm = lvl[1] && !wr_i;
      CLS_ROUTE:                 perm = (lvl == LVL_ROUTE);
      default:                   known_cls = 1'b0;
    endcase
    if (!ns_i)                allow_o = 1'b1;
    else if (!known_cls)      allow_o = 1'b0;
    else if (irq_ns_i[irq_i]) allow_o = 1'b1;
    else                      allow_o = perm;
  end
endmodule

// File: rtl/nsg_gate.sv
module nsg_gate #(
  parameter int unsigned RANGE    = 1,
  localparam int unsigned NUM_REGS = (RANGE + 1) * 2,
  localparam int unsigned NUM_IRQ  = NUM_REGS * 16,
  localparam int unsigned IRQ_W    = $clog2(NUM_IRQ),
  localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_en_i,
  input  logic [NUM_IRQ-1:0] irq_ns_i,
  input  logic [NUM_IRQ-1:0] cfg_ok_i,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic               reg_ns_i,
  input  logic [15:0]        reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [IRQ_W-1:0]   chk_irq_i,
  input  logic [2:0]         chk_cls_i,
  input  logic               chk_wr_i,
  input  logic               chk_ns_i,
  output logic               chk_allow_o
);
  logic                 hit;
  logic [REG_W-1:0]     idx;
  logic                 sec_wr;
  logic [31:0]          rd_word;
  logic [2*NUM_IRQ-1:0] lvl_q;
  logic [2*NUM_IRQ-1:0] eff_lvl;

  nsg_addr_dec #(.NUM_REGS(NUM_REGS)) u_dec (
    .addr_i (reg_addr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  assign sec_wr = reg_req_i && reg_we_i && !reg_ns_i && ext_en_i && hit;

  nsg_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (sec_wr),
    .idx_i     (idx),
    .wdata_i   (reg_wdata_i),
    .cfg_ok_i  (cfg_ok_i),
    .lvl_q_o   (lvl_q),
    .rd_word_o (rd_word)
  );

  assign reg_rdata_o = (reg_req_i && !reg_we_i && !reg_ns_i && ext_en_i && hit)
                       ? rd_word : 32'h0;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_eff
    assign eff_lvl[2*i +: 2] = lvl_q[2*i +: 2] & {2{cfg_ok_i[i] && ext_en_i}};
  end

  nsg_check #(.NUM_IRQ(NUM_IRQ)) u_chk_logic (
    .eff_lvl_i (eff_lvl),
    .irq_ns_i  (irq_ns_i),
    .irq_i     (chk_irq_i),
    .cls_i     (chk_cls_i),
    .wr_i      (chk_wr_i),
    .ns_i      (chk_ns_i),
    .allow_o   (chk_allow_o)
  );
endmodule

// File: rtl/nsg_gate_chk.sv
module nsg_gate_chk #(
  parameter int unsigned NUM_IRQ = 64,
  localparam int unsigned IRQ_W  = $clog2(NUM_IRQ)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ext_en_i,
  input logic [NUM_IRQ-1:0]   irq_ns_i,
  input logic                 reg_req_i,
  input logic                 reg_we_i,
  input logic                 reg_ns_i,
  input logic [31:0]          reg_rdata_o,
  input logic [IRQ_W-1:0]     chk_irq_i,
  input logic [2:0]           chk_cls_i,
  input logic                 chk_wr_i,
  input logic                 chk_ns_i,
  input logic                 chk_allow_o,
  input logic [2*NUM_IRQ-1:0] lvl_q
);
  // R6
  secure_req_allowed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_ns_i |-> chk_allow_o);

  // R10
  ns_active_write_denied_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_ns_i && chk_wr_i && chk_cls_i == 3'd2 && !irq_ns_i[chk_irq_i]) |-> !chk_allow_o);

  // R12
  reserved_cls_denied_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_ns_i && chk_cls_i > 3'd5) |-> !chk_allow_o);

  // R3
  ns_write_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && reg_we_i && reg_ns_i) |=> $stable(lvl_q));

  // R3
  ns_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && reg_ns_i) |-> reg_rdata_o == 32'h0);

  // R5
  absent_range_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_i |=> $stable(lvl_q));

  // R5
  absent_range_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_i |-> reg_rdata_o == 32'h0);
endmodule

bind nsg_gate nsg_gate_chk #(.NUM_IRQ(NUM_IRQ)) u_gate_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ext_en_i    (ext_en_i),
  .irq_ns_i    (irq_ns_i),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_ns_i    (reg_ns_i),
  .reg_rdata_o (reg_rdata_o),
  .chk_irq_i   (chk_irq_i),
  .chk_cls_i   (chk_cls_i),
  .chk_wr_i    (chk_wr_i),
  .chk_ns_i    (chk_ns_i),
  .chk_allow_o (chk_allow_o),
  .lvl_q       (lvl_q)
);

// File: tb/tb_nsg_gate.sv
module tb_nsg_gate;
  localparam int unsigned RANGE   = 1;
  localparam int unsigned NUM_IRQ = (RANGE + 1) * 32;
  localparam int unsigned IRQ_W   = $clog2(NUM_IRQ);
  localparam int unsigned NVEC    = 17;

  // {irq[5:0], cls[2:0], wr, ns, expected allow}
  localparam logic [11:0] VEC [NVEC] = '{
    {6'd0,  3'd0, 1'b0, 1'b1, 1'b0},  // R7 lvl0 set-pend
    {6'd1,  3'd0, 1'b1, 1'b1, 1'b1},  // R8 lvl1 set-pend write
    {6'd1,  3'd1, 1'b1, 1'b1, 1'b0},  // R8 lvl1 clr-pend denied
    {6'd1,  3'd4, 1'b1, 1'b1, 1'b1},  // R8 lvl1 msg-set
    {6'd1,  3'd5, 1'b1, 1'b1, 1'b0},  // R8 lvl1 msg-clr denied
    {6'd2,  3'd1, 1'b0, 1'b1, 1'b1},  // R9 lvl2 clr-pend read
    {6'd2,  3'd2, 1'b0, 1'b1, 1'b1},  // R9 lvl2 active read
    {6'd2,  3'd2, 1'b1, 1'b1, 1'b0},  // R10 lvl2 active write
    {6'd2,  3'd3, 1'b0, 1'b1, 1'b0},  // R9 lvl2 route denied
    {6'd3,  3'd3, 1'b1, 1'b1, 1'b1},  // R11 lvl3 route write
    {6'd3,  3'd5, 1'b1, 1'b1, 1'b1},  // R11 lvl3 msg-clr
    {6'd5,  3'd0, 1'b0, 1'b1, 1'b0},  // R4 non-configurable
    {6'd8,  3'd3, 1'b1, 1'b1, 1'b1},  // R6 ns-group irq
    {6'd0,  3'd3, 1'b1, 1'b0, 1'b1},  // R6 secure request
    {6'd3,  3'd6, 1'b0, 1'b1, 1'b0},  // R12 reserved class
    {6'd48, 3'd3, 1'b0, 1'b1, 1'b1},  // R2 last word, lvl3
    {6'd3,  3'd2, 1'b1, 1'b1, 1'b0}   // R10 lvl3 active write
  };

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               ext_en_i = 1'b1;
  logic [NUM_IRQ-1:0] irq_ns_i = '0;
  logic [NUM_IRQ-1:0] cfg_ok_i = '1;
  logic               reg_req_i = 1'b0;
  logic               reg_we_i = 1'b0;
  logic               reg_ns_i = 1'b0;
  logic [15:0]        reg_addr_i = '0;
  logic [31:0]        reg_wdata_i = '0;
  logic [31:0]        reg_rdata_o;
  logic [IRQ_W-1:0]   chk_irq_i = '0;
  logic [2:0]         chk_cls_i = '0;
  logic               chk_wr_i = 1'b0;
  logic               chk_ns_i = 1'b0;
  logic               chk_allow_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  nsg_gate #(.RANGE(RANGE)) dut (.*);

  task automatic reg_wr(input logic [15:0] a, input logic [31:0] d, input logic ns);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_ns_i = ns; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0; reg_ns_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [15:0] a, input logic ns, input logic [31:0] exp,
                        input string req);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b0; reg_ns_i = ns; reg_addr_i = a;
    #1;
    n_vec++;
    if (reg_rdata_o !== exp) begin
      n_bad++;
      $display("FAIL %s: read 0x%04h got 0x%08h exp 0x%08h", req, a, reg_rdata_o, exp);
    end
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_ns_i = 1'b0;
  endtask

  task automatic chk(input int irq, input logic [2:0] cls, input logic wr, input logic ns,
                     input logic exp, input string req);
    @(negedge clk_i);
    chk_irq_i = IRQ_W'(irq); chk_cls_i = cls; chk_wr_i = wr; chk_ns_i = ns;
    #1;
    n_vec++;
    if (chk_allow_o !== exp) begin
      n_bad++;
      $display("FAIL %s: irq %0d cls %0d wr %0b ns %0b allow got %0b exp %0b",
               req, irq, cls, wr, ns, chk_allow_o, exp);
    end
  endtask

  initial begin
    irq_ns_i[8] = 1'b1;
    cfg_ok_i[5] = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    reg_rd(16'h3600, 1'b0, 32'h0, "R1");
    chk(48, 3'd3, 1'b0, 1'b1, 1'b0, "R1");
    chk(0, 3'd0, 1'b1, 1'b1, 1'b0, "R1");

    // load levels: word0 field x = x mod 4, word3 all 0b11
    reg_wr(16'h3600, 32'hE4E4E4E4, 1'b0);
    reg_wr(16'h360C, 32'hFFFFFFFF, 1'b0);
    reg_rd(16'h3600, 1'b0, 32'hE4E4E0E4, "R2");
    reg_rd(16'h360C, 1'b0, 32'hFFFFFFFF, "R2");

    for (int i = 0; i < NVEC; i++) begin
      chk(int'(VEC[i][11:6]), VEC[i][5:3], VEC[i][2], VEC[i][1], VEC[i][0], "R6-R12 table");
    end

    // R3 non-secure register accesses
    reg_rd(16'h3600, 1'b1, 32'h0, "R3");
    reg_wr(16'h3604, 32'hFFFFFFFF, 1'b1);
    reg_rd(16'h3604, 1'b0, 32'h0, "R3");
    chk(16, 3'd0, 1'b0, 1'b1, 1'b0, "R3");

    // R2 out of range and misaligned
    reg_rd(16'h3610, 1'b0, 32'h0, "R2");
    reg_rd(16'h3601, 1'b0, 32'h0, "R2");
    reg_wr(16'h3610, 32'hFFFFFFFF, 1'b0);
    reg_wr(16'h3606, 32'hFFFFFFFF, 1'b0);
    reg_rd(16'h3604, 1'b0, 32'h0, "R2");
    reg_rd(16'h3600, 1'b0, 32'hE4E4E0E4, "R2");

    // R4 dropped write stays dropped once configurable
    cfg_ok_i[5] = 1'b1;
    reg_rd(16'h3600, 1'b0, 32'hE4E4E0E4, "R4");
    chk(5, 3'd0, 1'b0, 1'b1, 1'b0, "R4");
    cfg_ok_i[5] = 1'b0;

    // R5 extended range absent
    @(negedge clk_i);
    ext_en_i = 1'b0;
    reg_rd(16'h360C, 1'b0, 32'h0, "R5");
    chk(3, 3'd0, 1'b0, 1'b1, 1'b0, "R5");
    chk(8, 3'd0, 1'b0, 1'b1, 1'b1, "R5");
    reg_wr(16'h3608, 32'hFFFFFFFF, 1'b0);
    @(negedge clk_i);
    ext_en_i = 1'b1;
    reg_rd(16'h3608, 1'b0, 32'h0, "R5");
    reg_rd(16'h360C, 1'b0, 32'hFFFFFFFF, "R5");

    // R13 new level used on the next cycle
    chk(16, 3'd0, 1'b0, 1'b1, 1'b0, "R13");
    chk_ns_i = 1'b1;
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_ns_i = 1'b0;
    reg_addr_i = 16'h3604; reg_wdata_i = 32'h00000001;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
    #1;
    n_vec++;
    if (chk_allow_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R13: allow got %0b exp 1", chk_allow_o);
    end
    chk(16, 3'd1, 1'b0, 1'b1, 1'b0, "R13");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule